// File: doc/BRIEF.md
# Host Controller Interrupt Event Aggregator

This block gathers interrupt events inside a serial-bus host controller and turns them into one active-low interrupt line. A main event register holds one bit per internal event source. A second, smaller register holds one bit per isochronous transmit context. The OR of the transmit-context bits appears as a summary bit inside the main event register, which gives a two-level event hierarchy.

Every event and mask register has two write addresses. One address sets bits and the other clears them. The hardware sources set event bits directly. The top bit of the main mask register is a master enable that gates the whole interrupt line. A combinational read port returns register contents. At the clear address of each event register, the read returns the event bits ANDed with their mask.

Top module: `hc_irq_aggregator`

## Requirements
- R1: After reset all event and mask registers read 0 at every address, and `irq_n` is 1.
- R2: The 3-bit register addresses are: 0 main event set, 1 main event clear, 2 main mask set, 3 main mask clear, 4 transmit event set, 5 transmit event clear, 6 transmit mask set, 7 transmit mask clear. A write of 1 at a set address sets that bit and a write of 1 at a clear address clears it. A 0 leaves the bit unchanged. Main event bits 31:30 always read 0.
- R3: Bit 31 of the main mask is the master enable. While it is 0, `irq_n` stays 1 whatever events are pending.
- R4: While the master enable is 1 and (event AND mask) over bits 29:0 is nonzero, `irq_n` is 0. The line follows register state with one clock of latency.
- R5: Transmit context i sets its event bit when `tx_done[i]` is high and its two-bit interrupt field `tx_ifield[2i+1:2i]` equals 2'b11. Any other field value sets nothing.
- R6: Only bits 3:0 of the transmit event and transmit mask registers exist. Bits 31:4 read 0 and ignore writes.
- R7: Main event bit 6 is the OR of the transmit event bits. Writes to bit 6 have no effect, so the bit clears only when all four transmit bits are clear.
- R8: A read at address 1 returns main event AND main mask. A read at address 5 returns transmit event AND transmit mask. Reads at all other addresses return the register itself.
- R9: When a hardware set and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R10: A pulse on `hw_evt[i]` sets main event bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data (ones select bits) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| hw_evt | input | 30 | Hardware event set pulses, main register |
| tx_done | input | 4 | Per-context packet-sent pulses |
| tx_ifield | input | 8 | Per-context descriptor interrupt fields, 2 bits each |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults: 30 main event bits, 4 transmit contexts, the summary at bit 6 and a registered interrupt output. With these values the bench can reach the dead bits of both register pairs: bits 31:30 of the main event register and bits 31:4 of the transmit registers. It can also reach the summary bit's interplay with the context bits and the one-cycle interrupt latency. A scoreboard queue carries each expected read value and interrupt level to a monitor. The stimulus includes cycles where a set and a clear collide, for both the main and the transmit registers.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
   localparam int REG_W = 32;
   typedef enum logic [2:0] {
      A_EVT_SET = 3'd0,
      A_EVT_CLR = 3'd1,
      A_MSK_SET = 3'd2,
      A_MSK_CLR = 3'd3,
      A_TXE_SET = 3'd4,
      A_TXE_CLR = 3'd5,
      A_TXM_SET = 3'd6,
      A_TXM_CLR = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/hc_setclr_reg.sv
module hc_setclr_reg #(
   parameter int             W    = 32,
   parameter logic [W-1:0]   LIVE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sw_set,
   input  logic [W-1:0] sw_clr,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (((q | sw_set) & ~sw_clr) | hw_set) & LIVE;
   end

   p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set != '0) |=> ((q & $past(hw_set & LIVE)) == $past(hw_set & LIVE)));
   p_sw_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr != '0) |=> ((q & $past(sw_clr & ~hw_set)) == '0));
   p_dead_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~LIVE) == '0);
endmodule

// File: rtl/hc_tx_events.sv
module hc_tx_events #(
   parameter int W    = 32,
   parameter int N_TX = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      sw_set,
   input  logic [W-1:0]      sw_clr,
   input  logic [N_TX-1:0]   tx_done,
   input  logic [2*N_TX-1:0] tx_ifield,
   output logic [W-1:0]      tx_evt,
   output logic              tx_any
);
   localparam logic [W-1:0] TX_LIVE = (W'(1) << N_TX) - W'(1);

   logic [W-1:0] hw_set;

   always_comb begin
      hw_set = '0;
      for (int i = 0; i < N_TX; i++)
         hw_set[i] = tx_done[i] && (tx_ifield[2*i +: 2] == 2'b11);
   end

   hc_setclr_reg #(.W(W), .LIVE(TX_LIVE)) u_txe (
      .clk(clk), .rst_n(rst_n), .sw_set(sw_set), .sw_clr(sw_clr),
      .hw_set(hw_set), .q(tx_evt));

   assign tx_any = |tx_evt;

   for (genvar g = 0; g < N_TX; g++) begin : g_ctx
      p_ctx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_done[g] && tx_ifield[2*g +: 2] == 2'b11) |=> tx_evt[g]);
   end
endmodule

// File: rtl/hc_irq_line.sv
module hc_irq_line #(
   parameter int N_EVT   = 30,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] pend_vec,
   input  logic             master,
   output logic             irq_n
);
   logic fire;
   assign fire = master && (|pend_vec);

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b1;
         else        irq_q <= !fire;
      end
      assign irq_n = irq_q;

      p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !master |=> irq_n);
      p_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (master && pend_vec != '0) |=> !irq_n);
   end else begin : g_comb
      assign irq_n = !fire;

      p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !master |-> irq_n);
   end
endmodule

// File: rtl/hc_irq_aggregator.sv
module hc_irq_aggregator
   import hc_irq_pkg::*;
#(
   parameter int N_EVT   = 30,
   parameter int N_TX    = 4,
   parameter int SUM_BIT = 6,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [2:0]        rd_addr,
   output logic [31:0]       rd_data,
   input  logic [N_EVT-1:0]  hw_evt,
   input  logic [N_TX-1:0]   tx_done,
   input  logic [2*N_TX-1:0] tx_ifield,
   output logic              irq_n
);
   localparam int W = REG_W;
   localparam logic [W-1:0] ALL_EVT  = (W'(1) << N_EVT) - W'(1);
   localparam logic [W-1:0] SUM_M    = W'(1) << SUM_BIT;
   localparam logic [W-1:0] EVT_LIVE = ALL_EVT & ~SUM_M;
   localparam logic [W-1:0] MSK_LIVE = ALL_EVT | (W'(1) << (W-1));
   localparam logic [W-1:0] TX_LIVE  = (W'(1) << N_TX) - W'(1);

   if (N_EVT < 1 || N_EVT > W-2 || N_TX < 1 || N_TX > W || SUM_BIT >= N_EVT || SUM_BIT < 0)
   begin : g_bad_cfg
      $error("hc_irq_aggregator: illegal parameter combination");
   end

   function automatic logic [W-1:0] sel(input logic hit, input logic [W-1:0] d);
      return hit ? d : '0;
   endfunction

   logic [W-1:0] evt_q, msk_q, txe_q, txm_q, evt_view, hw_main;
   logic         tx_any;

   assign hw_main = W'(hw_evt) & EVT_LIVE;

   hc_setclr_reg #(.W(W), .LIVE(EVT_LIVE)) u_evt (
      .clk(clk), .rst_n(rst_n),
      .sw_set(sel(wr_en && wr_addr == A_EVT_SET, wr_data)),
      .sw_clr(sel(wr_en && wr_addr == A_EVT_CLR, wr_data)),
      .hw_set(hw_main), .q(evt_q));

   hc_setclr_reg #(.W(W), .LIVE(MSK_LIVE)) u_msk (
      .clk(clk), .rst_n(rst_n),
      .sw_set(sel(wr_en && wr_addr == A_MSK_SET, wr_data)),
      .sw_clr(sel(wr_en && wr_addr == A_MSK_CLR, wr_data)),
      .hw_set('0), .q(msk_q));

   hc_tx_events #(.W(W), .N_TX(N_TX)) u_txe (
      .clk(clk), .rst_n(rst_n),
      .sw_set(sel(wr_en && wr_addr == A_TXE_SET, wr_data)),
      .sw_clr(sel(wr_en && wr_addr == A_TXE_CLR, wr_data)),
      .tx_done(tx_done), .tx_ifield(tx_ifield),
      .tx_evt(txe_q), .tx_any(tx_any));

   hc_setclr_reg #(.W(W), .LIVE(TX_LIVE)) u_txm (
      .clk(clk), .rst_n(rst_n),
      .sw_set(sel(wr_en && wr_addr == A_TXM_SET, wr_data)),
      .sw_clr(sel(wr_en && wr_addr == A_TXM_CLR, wr_data)),
      .hw_set('0), .q(txm_q));

   assign evt_view = evt_q | (tx_any ? SUM_M : '0);

   always_comb begin
      unique case (reg_addr_e'(rd_addr))
         A_EVT_SET:            rd_data = evt_view;
         A_EVT_CLR:            rd_data = evt_view & msk_q;
         A_MSK_SET, A_MSK_CLR: rd_data = msk_q;
         A_TXE_SET:            rd_data = txe_q;
         A_TXE_CLR:            rd_data = txe_q & txm_q;
         default:              rd_data = txm_q;
      endcase
   end

   hc_irq_line #(.N_EVT(N_EVT), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .pend_vec(evt_view[N_EVT-1:0] & msk_q[N_EVT-1:0]),
      .master(msk_q[W-1]), .irq_n(irq_n));

   p_sum_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_EVT_CLR && wr_data[SUM_BIT] && txe_q != '0) |=> evt_view[SUM_BIT]);
   p_tx_hi_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr >= 3'd4) |-> ((rd_data & ~TX_LIVE) == '0));
endmodule

// File: tb/test_hc_irq_aggregator.sv
module test_hc_irq_aggregator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [29:0] hw_evt = '0;
   logic [3:0]  tx_done = '0;
   logic [7:0]  tx_ifield = '0;
   logic        irq_n;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [2:0]  addr;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   hc_irq_aggregator i_hc_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .hw_evt(hw_evt), .tx_done(tx_done), .tx_ifield(tx_ifield),
      .irq_n(irq_n));

   // monitor: compare queued expectations away from the rising edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         total++;
         if (it.is_irq) begin
            if (irq_n !== it.exp[0]) begin
               bad++;
               $display("FAIL %s: irq_n actual=%0b expected=%0b", it.tag, irq_n, it.exp[0]);
            end
         end else if (rd_data !== it.exp) begin
            bad++;
            $display("FAIL %s: addr %0d actual=%h expected=%h", it.tag, it.addr, rd_data, it.exp);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic drive(input bit we, input logic [2:0] a, input logic [31:0] d,
                        input logic [29:0] hw, input logic [3:0] dn, input logic [7:0] fld);
      wr_en = we; wr_addr = a; wr_data = d; hw_evt = hw; tx_done = dn; tx_ifield = fld;
      tick();
      wr_en = 1'b0; wr_data = '0; hw_evt = '0; tx_done = '0; tx_ifield = '0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      drive(1'b1, a, d, '0, '0, '0);
   endtask

   task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
      item_t it;
      rd_addr = a;
      it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
      sb.push_back(it);
      tick();
   endtask

   task automatic exp_irq(input logic v, input string tag);
      item_t it;
      it.is_irq = 1'b1; it.addr = '0; it.exp = {31'd0, v}; it.tag = tag;
      sb.push_back(it);
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      for (int a = 0; a < 8; a++) exp_rd(3'(a), 32'h0, "R1 reset");
      exp_irq(1'b1, "R1 reset irq");

      // R2 mask set, R3 nothing pending
      wr(3'd2, 32'h8000_0005);
      exp_rd(3'd2, 32'h8000_0005, "R2 mask set");
      exp_rd(3'd3, 32'h8000_0005, "R8 mask at clear addr");
      exp_irq(1'b1, "R4 no event");

      // R4 enabled event fires
      wr(3'd0, 32'h1);
      exp_rd(3'd0, 32'h1, "R2 event set");
      exp_rd(3'd1, 32'h1, "R8 event and mask");
      exp_irq(1'b0, "R4 fire");

      // R2 zero write no change, one clears
      wr(3'd1, 32'h0);
      exp_rd(3'd0, 32'h1, "R2 zero write");
      wr(3'd1, 32'h1);
      exp_rd(3'd0, 32'h0, "R2 clear");
      exp_irq(1'b1, "R4 released");

      // R3 master off gates line
      wr(3'd3, 32'h8000_0000);
      wr(3'd0, 32'h4);
      tick();
      exp_irq(1'b1, "R3 master off");
      wr(3'd2, 32'h8000_0000);
      tick();
      exp_irq(1'b0, "R4 master on");
      wr(3'd1, 32'h4);
      tick();
      exp_irq(1'b1, "R4 cleared");

      // R8 unmasked event
      wr(3'd0, 32'h2);
      exp_rd(3'd1, 32'h0, "R8 unmasked");
      exp_irq(1'b1, "R4 unmasked no irq");
      wr(3'd1, 32'h2);

      // R10 hardware event, R2 dead bits
      drive(1'b0, 3'd0, 32'h0, 30'h8, 4'h0, 8'h0);
      exp_rd(3'd0, 32'h8, "R10 hw set");
      wr(3'd0, 32'hC000_0000);
      exp_rd(3'd0, 32'h8, "R2 bits 31:30 dead");

      // R5 transmit contexts
      drive(1'b0, 3'd0, 32'h0, '0, 4'b0100, 8'b0010_0000);
      exp_rd(3'd4, 32'h0, "R5 field not 11");
      drive(1'b0, 3'd0, 32'h0, '0, 4'b0100, 8'b0011_0000);
      exp_rd(3'd4, 32'h4, "R5 field 11");
      exp_rd(3'd0, 32'h48, "R7 summary set");

      // R6 dead transmit bits, R8 clear-address read
      wr(3'd4, 32'hFFFF_FFF0);
      exp_rd(3'd4, 32'h4, "R6 upper ignored");
      wr(3'd4, 32'h1);
      exp_rd(3'd4, 32'h5, "R2 tx set");
      exp_rd(3'd5, 32'h0, "R8 tx mask zero");
      wr(3'd6, 32'hFFFF_FFFF);
      exp_rd(3'd6, 32'hF, "R6 tx mask width");
      exp_rd(3'd5, 32'h5, "R8 tx and");

      // R7 summary only follows context bits
      wr(3'd1, 32'h40);
      exp_rd(3'd0, 32'h48, "R7 direct clear ignored");
      wr(3'd5, 32'h1);
      exp_rd(3'd0, 32'h48, "R7 one ctx left");
      wr(3'd5, 32'h4);
      exp_rd(3'd0, 32'h08, "R7 all ctx clear");

      // R9 set beats clear
      drive(1'b1, 3'd1, 32'h8, 30'h8, 4'h0, 8'h0);
      exp_rd(3'd0, 32'h8, "R9 main collide");
      wr(3'd1, 32'h8);
      exp_rd(3'd0, 32'h0, "R2 main clear");
      drive(1'b1, 3'd5, 32'h2, '0, 4'b0010, 8'b0000_1100);
      exp_rd(3'd4, 32'h2, "R9 tx collide");

      // R7 summary raises interrupt through mask bit 6
      exp_irq(1'b1, "R4 summary unmasked");
      wr(3'd2, 32'h40);
      tick();
      exp_irq(1'b0, "R7 summary irq");
      wr(3'd5, 32'h2);
      tick();
      exp_irq(1'b1, "R7 summary gone");

      tick();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule